// File: doc/BRIEF.md
# Four-Lane Deskew and Word Assembler

This block sits behind four per-lane elastic buffers. All four lanes arrive on one system clock, so each lane delivers one decoded byte per cycle with a control-character flag and a valid strobe. In wide (4X) mode the block finds a programmable alignment control character on every lane. It measures how many cycles each lane's marker trails the earliest one, and delays the early lanes by that amount. Once the markers line up, one byte from each lane is packed into a single ordered 32-bit word together with a 4-bit control mask.

In narrow (1X) mode no deskew takes place. Lane 0 is passed straight to the top byte of the output word, and the other lanes are ignored. The alignment state is held cleared in 1X mode, and a change of the mode input forces a fresh acquisition.

The reset `rst_n` is asynchronous and active low. The integrating chip releases it synchronously to `clk`.

Top module: `quad_lane_deskew`

## Requirements
- R1: While `rst_n` is low, `word_vld`, `locked`, `word_out` and `word_ctl` are all zero.
- R2: With `mode_4x` low, each cycle's lane 0 input appears after the next rising edge as `word_out = {lane0 byte, 24'h0}`, `word_ctl = {lane0 ctl, 3'b000}` and `word_vld = lane 0 valid`. The bytes, flags and valid strobes of lanes 1 to 3 have no effect on the outputs.
- R3: A lane carries an alignment marker only in a cycle where its valid is 1, its control flag is 1 and its byte equals `align_code`. A byte equal to the code with the flag at 0, or a control byte that differs from the code, does not start alignment.
- R4: In 4X mode the first marker seen on any lane sets offset 0. Each lane's delay becomes (offset of the last lane's marker) minus (its own offset). `locked` rises right after the edge that samples the last lane's marker, and the delays do not change while `locked` stays high.
- R5: If all four lanes have not shown a marker by offset 4, the attempt is discarded and `locked` stays low. A skew of exactly 4 cycles is accepted.
- R6: Lane 0 occupies `word_out[31:24]`, lane 1 `[23:16]`, lane 2 `[15:8]` and lane 3 `[7:0]`. `word_ctl[3]` carries lane 0's flag, down to `word_ctl[0]` for lane 3.
- R7: While locked in 4X mode, the aligned column formed in a cycle appears after the next edge. `word_vld` is 1 only if all four aligned bytes are valid. After lock, the bytes that followed each lane's marker come out as one word.
- R8: In 4X mode, no `word_vld` is produced for any column formed while `locked` is low.
- R9: While locked, an aligned column with markers on every lane keeps the lock and is output with mask 4'hF. An aligned column with markers on some but not all lanes drops `locked` after that edge, is not output, and returns the block to acquisition.
- R10: A change of `mode_4x`, and any cycle in 1X mode, leaves `locked` low after the next edge. Alignment must then be acquired again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_4x | input | 1 | 1 = four-lane deskew mode, 0 = lane 0 pass-through |
| align_code | input | 8 | Byte value that, with the control flag set, marks an alignment column |
| lane_byte | input | 32 | Lane bytes, lane n in bits 8n+7:8n |
| lane_ctl | input | 4 | Control-character flag per lane |
| lane_vld | input | 4 | Valid strobe per lane |
| word_out | output | 32 | Assembled word, lane 0 in the top byte |
| word_ctl | output | 4 | Control mask, bit 3 for lane 0 down to bit 0 for lane 3 |
| word_vld | output | 1 | Output word valid |
| locked | output | 1 | Alignment acquired in 4X mode |

## Verification
Every output is registered once, so a lane column driven before edge k is seen on the outputs just after edge k. Acquisition follows the same rule: when the last lane's marker is sampled at edge T, `locked` is high after T and the first aligned data word is visible after edge T+1. The bench drives each column 1 ns after a rising edge and reads the outputs 1 ns after the next edge. Each check is therefore tied to exactly one driven column, and the expected words are built from per-lane offsets and a lane/sequence byte pattern.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

  localparam int SYM_BITS = 8;

  // One lane symbol as carried through a delay line
  typedef struct packed {
    logic                vld;
    logic                ctl;
    logic [SYM_BITS-1:0] dat;
  } lane_sym_t;

  typedef enum logic [1:0] {
    ACQ_IDLE = 2'd0,
    ACQ_WAIT = 2'd1,
    ACQ_LOCK = 2'd2
  } acq_state_t;

endpackage

// File: rtl/dsk_lane_delay.sv
module dsk_lane_delay
  import dsk_pkg::*;
#(
  parameter int MAX_DLY = 4,
  parameter int SEL_W   = $clog2(MAX_DLY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  lane_sym_t        in_sym,
  input  logic [SEL_W-1:0] tap_sel,
  output lane_sym_t        out_sym
);

  lane_sym_t stage_q [MAX_DLY];
  lane_sym_t stage_d [MAX_DLY];

  // next-state: unconditional shift, one symbol per system clock
  always_comb begin
    stage_d[0] = in_sym;
    for (int j = 1; j < MAX_DLY; j++) begin
      stage_d[j] = stage_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < MAX_DLY; j++) begin
        stage_q[j] <= '0;
      end
    end else begin
      for (int j = 0; j < MAX_DLY; j++) begin
        stage_q[j] <= stage_d[j];
      end
    end
  end

  // tap 0 is the live input, tap n is the input from n cycles ago
  always_comb begin
    out_sym = in_sym;
    for (int j = 0; j < MAX_DLY; j++) begin
      if (tap_sel == SEL_W'(j + 1)) begin
        out_sym = stage_q[j];
      end
    end
  end

  AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tap_sel <= SEL_W'(MAX_DLY)); // R4

endmodule

// File: rtl/dsk_align_fsm.sv
module dsk_align_fsm
  import dsk_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int MAX_DLY = 4,
  parameter int SEL_W   = $clog2(MAX_DLY + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        mode_4x,
  input  logic [LANES-1:0]            raw_mk,
  input  logic [LANES-1:0]            col_mk,
  output logic [LANES-1:0][SEL_W-1:0] dly,
  output logic                        locked,
  output logic                        col_break
);

  acq_state_t                  st_q,   st_d;
  logic                        mode_q;
  logic [LANES-1:0]            seen_q, seen_d;
  logic [SEL_W-1:0]            cnt_q,  cnt_d;
  logic [LANES-1:0][SEL_W-1:0] arr_q,  arr_d;
  logic [LANES-1:0][SEL_W-1:0] dly_q,  dly_d;
  logic                        mode_chg;
  logic                        all_seen;

  assign mode_chg  = (mode_4x != mode_q);
  assign col_break = (|col_mk) && !(&col_mk);
  assign all_seen  = &(seen_q | raw_mk);

  always_comb begin
    st_d   = st_q;
    seen_d = seen_q;
    cnt_d  = cnt_q;
    arr_d  = arr_q;
    dly_d  = dly_q;
    if (mode_chg || !mode_4x) begin
      st_d   = ACQ_IDLE;
      seen_d = '0;
      cnt_d  = '0;
      dly_d  = '0;
    end else begin
      unique case (st_q)
        ACQ_IDLE: begin
          if (|raw_mk) begin
            seen_d = raw_mk;
            arr_d  = '0;
            if (&raw_mk) begin
              dly_d  = '0;
              seen_d = '0;
              st_d   = ACQ_LOCK;
            end else begin
              cnt_d = SEL_W'(1);
              st_d  = ACQ_WAIT;
            end
          end
        end
        ACQ_WAIT: begin
          for (int i = 0; i < LANES; i++) begin
            if (raw_mk[i] && !seen_q[i]) arr_d[i] = cnt_q;
          end
          seen_d = seen_q | raw_mk;
          if (all_seen) begin
            for (int i = 0; i < LANES; i++) begin
              if (raw_mk[i] && !seen_q[i]) dly_d[i] = '0;
              else                         dly_d[i] = cnt_q - arr_q[i];
            end
            seen_d = '0;
            st_d   = ACQ_LOCK;
          end else if (cnt_q == SEL_W'(MAX_DLY)) begin
            seen_d = '0;
            cnt_d  = '0;
            st_d   = ACQ_IDLE;
          end else begin
            cnt_d = cnt_q + SEL_W'(1);
          end
        end
        ACQ_LOCK: begin
          if (col_break) begin
            cnt_d = '0;
            st_d  = ACQ_IDLE;
          end
        end
        default: st_d = ACQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ACQ_IDLE;
      mode_q <= 1'b0;
      seen_q <= '0;
      cnt_q  <= '0;
      arr_q  <= '0;
      dly_q  <= '0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_4x;
      seen_q <= seen_d;
      cnt_q  <= cnt_d;
      arr_q  <= arr_d;
      dly_q  <= dly_d;
    end
  end

  assign locked = (st_q == ACQ_LOCK);
  assign dly    = dly_q;

  AST_NARROW_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_4x |=> !locked); // R10
  AST_MODE_FLIP_RELOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_4x != mode_q) |=> !locked); // R10
  AST_BREAK_DROPS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && col_break) |=> !locked); // R9
  AST_DLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(dly_q)); // R4

endmodule

// File: rtl/dsk_word_pack.sv
module dsk_word_pack #(
  parameter int LANES = 4,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_4x,
  input  logic                    locked,
  input  logic                    col_break,
  input  logic [LANES*BYTE_W-1:0] col_dat,
  input  logic [LANES-1:0]        col_ctl,
  input  logic [LANES-1:0]        col_vld,
  input  logic [BYTE_W-1:0]       l0_dat,
  input  logic                    l0_ctl,
  input  logic                    l0_vld,
  output logic [LANES*BYTE_W-1:0] word_out,
  output logic [LANES-1:0]        word_ctl,
  output logic                    word_vld
);

  logic [LANES*BYTE_W-1:0] word_d;
  logic [LANES-1:0]        mask_d;
  logic                    vld_d;

  always_comb begin
    word_d = '0;
    mask_d = '0;
    if (mode_4x) begin
      for (int i = 0; i < LANES; i++) begin
        word_d[(LANES-1-i)*BYTE_W +: BYTE_W] = col_dat[i*BYTE_W +: BYTE_W];
        mask_d[LANES-1-i] = col_ctl[i];
      end
      vld_d = locked && (&col_vld) && !col_break;
    end else begin
      word_d[LANES*BYTE_W-1 -: BYTE_W] = l0_dat;
      mask_d[LANES-1] = l0_ctl;
      vld_d = l0_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_out <= '0;
      word_ctl <= '0;
      word_vld <= 1'b0;
    end else begin
      word_out <= word_d;
      word_ctl <= mask_d;
      word_vld <= vld_d;
    end
  end

  AST_NO_VLD_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_4x && !locked) |=> !word_vld); // R8
  AST_NARROW_FOLLOWS_L0: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_4x |=> (word_vld == $past(l0_vld))); // R2
  AST_BREAK_NOT_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_4x && col_break) |=> !word_vld); // R9

endmodule

// File: rtl/quad_lane_deskew.sv
module quad_lane_deskew
  import dsk_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int BYTE_W  = SYM_BITS,
  parameter int MAX_DLY = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    mode_4x,
  input  logic [BYTE_W-1:0]       align_code,
  input  logic [LANES*BYTE_W-1:0] lane_byte,
  input  logic [LANES-1:0]        lane_ctl,
  input  logic [LANES-1:0]        lane_vld,
  output logic [LANES*BYTE_W-1:0] word_out,
  output logic [LANES-1:0]        word_ctl,
  output logic                    word_vld,
  output logic                    locked
);

  localparam int SEL_W = $clog2(MAX_DLY + 1);

  logic [LANES-1:0][SEL_W-1:0] dly;
  logic [LANES-1:0]            raw_mk;
  logic [LANES-1:0]            col_mk;
  logic [LANES*BYTE_W-1:0]     col_dat;
  logic [LANES-1:0]            col_ctl;
  logic [LANES-1:0]            col_vld;
  logic                        col_break;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_sym_t in_sym;
    lane_sym_t out_sym;

    assign in_sym.vld = lane_vld[g];
    assign in_sym.ctl = lane_ctl[g];
    assign in_sym.dat = lane_byte[g*BYTE_W +: BYTE_W];

    dsk_lane_delay #(
      .MAX_DLY (MAX_DLY),
      .SEL_W   (SEL_W)
    ) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_sym  (in_sym),
      .tap_sel (dly[g]),
      .out_sym (out_sym)
    );

    assign raw_mk[g] = in_sym.vld && in_sym.ctl && (in_sym.dat == align_code);
    assign col_mk[g] = out_sym.vld && out_sym.ctl && (out_sym.dat == align_code);
    assign col_dat[g*BYTE_W +: BYTE_W] = out_sym.dat;
    assign col_ctl[g] = out_sym.ctl;
    assign col_vld[g] = out_sym.vld;
  end

  dsk_align_fsm #(
    .LANES   (LANES),
    .MAX_DLY (MAX_DLY),
    .SEL_W   (SEL_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_4x   (mode_4x),
    .raw_mk    (raw_mk),
    .col_mk    (col_mk),
    .dly       (dly),
    .locked    (locked),
    .col_break (col_break)
  );

  dsk_word_pack #(
    .LANES  (LANES),
    .BYTE_W (BYTE_W)
  ) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_4x   (mode_4x),
    .locked    (locked),
    .col_break (col_break),
    .col_dat   (col_dat),
    .col_ctl   (col_ctl),
    .col_vld   (col_vld),
    .l0_dat    (lane_byte[BYTE_W-1:0]),
    .l0_ctl    (lane_ctl[0]),
    .l0_vld    (lane_vld[0]),
    .word_out  (word_out),
    .word_ctl  (word_ctl),
    .word_vld  (word_vld)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |-> (!word_vld && !locked)); // R1

endmodule

// File: tb/quad_lane_deskew_tb.sv
`timescale 1ns/1ps
module quad_lane_deskew_tb;

  logic        clk;
  logic        rst_n;
  logic        mode_4x;
  logic [7:0]  align_code;
  logic [31:0] lane_byte;
  logic [3:0]  lane_ctl;
  logic [3:0]  lane_vld;
  logic [31:0] word_out;
  logic [3:0]  word_ctl;
  logic        word_vld;
  logic        locked;

  int tot = 0;
  int bad = 0;

  quad_lane_deskew u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_4x    (mode_4x),
    .align_code (align_code),
    .lane_byte  (lane_byte),
    .lane_ctl   (lane_ctl),
    .lane_vld   (lane_vld),
    .word_out   (word_out),
    .word_ctl   (word_ctl),
    .word_vld   (word_vld),
    .locked     (locked)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tot++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_lane(input int i, input logic [7:0] d, input logic c, input logic v);
    lane_byte[i*8 +: 8] = d;
    lane_ctl[i] = c;
    lane_vld[i] = v;
  endtask

  task automatic all_idle();
    for (int i = 0; i < 4; i++) set_lane(i, 8'h00, 1'b0, 1'b1);
  endtask

  function automatic logic [7:0] pat(input int i, input int k);
    return {2'(i), 6'(k)};
  endfunction

  function automatic logic [31:0] exp_word(input int k);
    logic [31:0] w;
    for (int i = 0; i < 4; i++) w[(3-i)*8 +: 8] = pat(i, k);
    return w;
  endfunction

  task automatic do_reset(input logic m);
    mode_4x = m;
    all_idle();
    rst_n = 1'b0;
    #1;
    chk("R1", "vld in reset", {31'b0, word_vld}, 32'h0);
    chk("R1", "locked in reset", {31'b0, locked}, 32'h0);
    chk("R1", "word in reset", word_out, 32'h0);
    chk("R1", "mask in reset", {28'b0, word_ctl}, 32'h0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
  endtask

  // lane n sends its marker at cycle off[n], then bytes pat(n,1), pat(n,2), ...
  task automatic run_skew(input int o0, input int o1, input int o2, input int o3);
    int off[4];
    int t_last;
    off = '{o0, o1, o2, o3};
    t_last = 0;
    for (int i = 0; i < 4; i++) if (off[i] > t_last) t_last = off[i];
    align_code = 8'hBC;
    do_reset(1'b1);
    for (int c = 0; c < t_last + 6; c++) begin
      for (int i = 0; i < 4; i++) begin
        if (c < off[i])       set_lane(i, 8'h00, 1'b0, 1'b1);
        else if (c == off[i]) set_lane(i, 8'hBC, 1'b1, 1'b1);
        else                  set_lane(i, pat(i, c - off[i]), 1'b0, 1'b1);
      end
      tick();
      if (c < t_last) begin
        chk("R4", "locked before last marker", {31'b0, locked}, 32'h0);
        chk("R8", "vld while acquiring", {31'b0, word_vld}, 32'h0);
      end else if (c == t_last) begin
        chk("R4", "locked after last marker", {31'b0, locked}, 32'h1);
        chk("R8", "vld on lock column", {31'b0, word_vld}, 32'h0);
      end else begin
        chk("R4", "lock held", {31'b0, locked}, 32'h1);
        chk("R7", "aligned vld", {31'b0, word_vld}, 32'h1);
        chk("R6", "aligned word", word_out, exp_word(c - t_last));
        chk("R6", "aligned mask", {28'b0, word_ctl}, 32'h0);
      end
    end
  endtask

  task automatic run_overskew();
    int off[4];
    off = '{0, 1, 2, 5};
    align_code = 8'hBC;
    do_reset(1'b1);
    for (int c = 0; c < 14; c++) begin
      for (int i = 0; i < 4; i++) begin
        if (c < off[i])       set_lane(i, 8'h00, 1'b0, 1'b1);
        else if (c == off[i]) set_lane(i, 8'hBC, 1'b1, 1'b1);
        else                  set_lane(i, pat(i, c - off[i]), 1'b0, 1'b1);
      end
      tick();
      chk("R5", "no lock past skew limit", {31'b0, locked}, 32'h0);
      chk("R8", "no vld past skew limit", {31'b0, word_vld}, 32'h0);
    end
  endtask

  task automatic run_marker_def();
    align_code = 8'hBC;
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) set_lane(i, 8'hBC, 1'b0, 1'b1);
    tick();
    tick();
    chk("R3", "code without flag", {31'b0, locked}, 32'h0);
    align_code = 8'h7C;
    for (int i = 0; i < 4; i++) set_lane(i, 8'hBC, 1'b1, 1'b1);
    tick();
    chk("R3", "flag with other code", {31'b0, locked}, 32'h0);
    for (int i = 0; i < 4; i++) set_lane(i, 8'h7C, 1'b1, 1'b1);
    tick();
    chk("R3", "programmed code locks", {31'b0, locked}, 32'h1);
  endtask

  task automatic run_locked_cols();
    align_code = 8'hBC;
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) set_lane(i, 8'hBC, 1'b1, 1'b1);
    tick();
    chk("R4", "zero skew lock", {31'b0, locked}, 32'h1);
    for (int i = 0; i < 4; i++) set_lane(i, pat(i, 9), 1'b0, 1'b1);
    set_lane(1, pat(1, 9), 1'b0, 1'b0);
    tick();
    chk("R7", "vld low with a lane invalid", {31'b0, word_vld}, 32'h0);
    chk("R7", "lock kept on invalid lane", {31'b0, locked}, 32'h1);
    for (int i = 0; i < 4; i++) set_lane(i, 8'hBC, 1'b1, 1'b1);
    tick();
    chk("R9", "full marker column keeps lock", {31'b0, locked}, 32'h1);
    chk("R9", "marker column vld", {31'b0, word_vld}, 32'h1);
    chk("R9", "marker column word", word_out, 32'hBCBCBCBC);
    chk("R6", "marker column mask", {28'b0, word_ctl}, 32'hF);
    for (int i = 0; i < 4; i++) set_lane(i, pat(i, 3), 1'b0, 1'b1);
    set_lane(0, 8'hBC, 1'b1, 1'b1);
    tick();
    chk("R9", "partial column drops lock", {31'b0, locked}, 32'h0);
    chk("R9", "partial column not output", {31'b0, word_vld}, 32'h0);
    all_idle();
    tick();
    chk("R8", "no vld after loss", {31'b0, word_vld}, 32'h0);
    for (int i = 0; i < 4; i++) set_lane(i, 8'hBC, 1'b1, 1'b1);
    tick();
    chk("R9", "reacquired", {31'b0, locked}, 32'h1);
  endtask

  task automatic run_mode();
    align_code = 8'hBC;
    do_reset(1'b1);
    for (int i = 0; i < 4; i++) set_lane(i, 8'hBC, 1'b1, 1'b1);
    tick();
    chk("R4", "locked before mode flip", {31'b0, locked}, 32'h1);
    mode_4x = 1'b0;
    for (int i = 1; i < 4; i++) set_lane(i, 8'hFF, 1'b1, 1'b1);
    set_lane(0, 8'h5A, 1'b1, 1'b1);
    tick();
    chk("R10", "unlocked after flip to 1X", {31'b0, locked}, 32'h0);
    chk("R2", "1X vld", {31'b0, word_vld}, 32'h1);
    chk("R2", "1X word", word_out, 32'h5A000000);
    chk("R2", "1X mask", {28'b0, word_ctl}, 32'h8);
    set_lane(0, 8'h33, 1'b0, 1'b0);
    tick();
    chk("R2", "1X follows lane 0 valid", {31'b0, word_vld}, 32'h0);
    set_lane(0, 8'hC3, 1'b0, 1'b1);
    for (int i = 1; i < 4; i++) set_lane(i, 8'hBC, 1'b1, 1'b0);
    tick();
    chk("R2", "1X ignores lanes 1-3 word", word_out, 32'hC3000000);
    chk("R2", "1X ignores lanes 1-3 vld", {31'b0, word_vld}, 32'h1);
    mode_4x = 1'b1;
    for (int i = 0; i < 4; i++) set_lane(i, pat(i, 1), 1'b0, 1'b1);
    tick();
    chk("R10", "unlocked after flip to 4X", {31'b0, locked}, 32'h0);
    chk("R8", "no vld after flip to 4X", {31'b0, word_vld}, 32'h0);
    tick();
    chk("R10", "still unlocked", {31'b0, locked}, 32'h0);
  endtask

  initial begin
    rst_n = 1'b0;
    mode_4x = 1'b1;
    align_code = 8'hBC;
    lane_byte = '0;
    lane_ctl = '0;
    lane_vld = '0;
    run_skew(0, 0, 0, 0);
    run_skew(0, 2, 1, 3);
    run_skew(4, 0, 2, 1);
    run_overskew();
    run_marker_def();
    run_locked_cols();
    run_mode();
    do_reset(1'b1);
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tot++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", tot, bad);
    $finish;
  end

endmodule